// File: doc/BRIEF.md
# Memory Protection Configuration Register Bank

This block holds the control state of a physical memory protection unit. It keeps one 8-bit configuration field per protection entry, one word-address register per entry, and a machine security register with three flags: lockdown, whitelist and lock bypass. Software reaches all of it through a simple single-cycle CSR-style port. The port can read or write a packed word of configuration bytes, a single address register, or the security register.

Every write passes through a filter before it lands. The filter applies per-entry locks and the top-of-range lock that the following entry holds over an address register. It also applies the sticky lockdown and whitelist flags, the lock-bypass flag, and the rule that removes a write-only permission pair. The stored state goes out on flat buses to the address-matching checker. A one-cycle pulse tells downstream caches that a rule really changed.

Top module: `pmp_csr_bank`

## Requirements
- R1: After reset, every configuration byte, address register and security flag reads as zero, and `rule_changed` is low.
- R2: Port selector encoding: 0 selects a packed configuration word, 1 selects an address register, 2 selects the security register, and 3 reads zero and writes nothing. Configuration byte layout: bit 0 R, bit 1 W, bit 2 X, bits 4:3 match mode (0 off, 1 TOR, 2 NA4, 3 NAPOT), bit 7 L. In configuration word n, byte i belongs to entry 4n+i, and a word holds XLEN/8 bytes.
- R3: While lockdown is clear, a configuration byte with W=1 and R=0 is stored with both W and R cleared. While lockdown is set, it is stored unchanged.
- R4: An entry is locked when its L bit is set and bypass is clear. While lockdown is clear, a write to a locked entry's configuration byte or address register leaves the entry unchanged. Neighbouring bytes in the same word are still written.
- R5: A write to address register k is ignored when entry k+1 has L set and match mode TOR.
- R6: While bypass is set, no entry is locked, and locked entries accept configuration writes.
- R7: Security register layout: bit 0 lockdown, bit 1 whitelist, bit 2 bypass. Bypass cannot change from 0 to 1 while any entry is locked, and it may always be cleared.
- R8: Once set, lockdown and whitelist stay set until reset. Writing 0 to them has no effect.
- R9: While lockdown is set, a configuration byte is accepted only in two cases, whether or not the entry is locked: the new value has L=1 and X=0, or the new value has L=0 and bits 2:0 not equal to 3'b110. Any other byte is dropped.
- R10: Configuration bytes for entries at or beyond NUM_ENTRIES, and address registers at such indices, read as zero and ignore writes.
- R11: `rule_changed` is high for exactly the one cycle after a write that changed a stored configuration byte or address register. It stays low after a write that leaves them as they were, and after a write to the security register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Write strobe, sampled on the rising edge |
| csr_sel | input | 2 | Register group selector |
| csr_idx | input | $clog2(NUM_ENTRIES)+1 | Word index (configuration) or entry index (address) |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Combinational read data for the selected register |
| cfg_flat | output | NUM_ENTRIES*8 | All configuration bytes, entry k at bits 8k+7:8k |
| addr_flat | output | NUM_ENTRIES*XLEN | All address registers, entry k at slice k |
| sec_mml | output | 1 | Lockdown flag |
| sec_mmwp | output | 1 | Whitelist flag |
| sec_rlb | output | 1 | Lock bypass flag |
| rule_changed | output | 1 | One-cycle pulse after a stored rule changed |

## Verification
The properties assume that a write takes effect only at the edge where `csr_we` is high, and that the port performs at most one access per cycle, so a lock and a write to the same entry never land on the same edge. The stimulus drives every access half a cycle before the capturing edge and drops the strobe in the following cycle. The flag-changing writes are ordered so that bypass is tested before any lock exists and lockdown is set last, because it cannot be undone without a reset.

// File: rtl/pmp_csr_bank.sv
module pmp_csr_bank #(
  parameter int NUM_ENTRIES = 16,
  parameter int XLEN        = 32,
  parameter bit ENHANCED    = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        csr_we,
  input  logic [1:0]                  csr_sel,
  input  logic [$clog2(NUM_ENTRIES):0] csr_idx,
  input  logic [XLEN-1:0]             csr_wdata,
  output logic [XLEN-1:0]             csr_rdata,
  output logic [NUM_ENTRIES*8-1:0]    cfg_flat,
  output logic [NUM_ENTRIES*XLEN-1:0] addr_flat,
  output logic                        sec_mml,
  output logic                        sec_mmwp,
  output logic                        sec_rlb,
  output logic                        rule_changed
);
  localparam int AW  = $clog2(NUM_ENTRIES);
  localparam int BPW = XLEN / 8;

  logic [7:0]      cfg_q  [NUM_ENTRIES];
  logic [7:0]      cfg_d  [NUM_ENTRIES];
  logic [XLEN-1:0] addr_q [NUM_ENTRIES];
  logic [XLEN-1:0] addr_d [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] lk, tor_blk;
  logic mml_d, mmwp_d, rlb_d, chg;

  for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_ent
    assign lk[k] = cfg_q[k][7] && !sec_rlb;
    assign cfg_flat[k*8 +: 8]        = cfg_q[k];
    assign addr_flat[k*XLEN +: XLEN] = addr_q[k];
    if (k < NUM_ENTRIES - 1) begin : g_nx
      assign tor_blk[k] = cfg_q[k+1][7] && (cfg_q[k+1][4:3] == 2'b01);
    end else begin : g_last
      assign tor_blk[k] = 1'b0;
    end
  end

  function automatic logic [8:0] cfg_filter(input logic [7:0] cur, input logic [7:0] nv,
                                            input logic mml, input logic rlb);
    logic ok;
    logic [7:0] v;
    if (ENHANCED)
      ok = rlb || (!mml && !(cur[7] && !rlb)) ||
           (mml && ((nv[7] && !nv[2]) || (!nv[7] && nv[2:0] != 3'b110)));
    else
      ok = !(cur[7] && !rlb);
    v = nv;
    if (v[1] && !v[0] && !mml) v[1:0] = 2'b00;
    return {ok, v};
  endfunction

  always_comb begin
    cfg_d  = cfg_q;
    addr_d = addr_q;
    mml_d  = sec_mml;
    mmwp_d = sec_mmwp;
    rlb_d  = sec_rlb;
    if (csr_we) begin
      case (csr_sel)
        2'd0: for (int k = 0; k < NUM_ENTRIES; k++) begin
          int off;
          logic [8:0] f;
          off = k - int'(csr_idx) * 4;
          if (off >= 0 && off < BPW) begin
            f = cfg_filter(cfg_q[k], csr_wdata[off*8 +: 8], sec_mml, sec_rlb);
            if (f[8]) cfg_d[k] = f[7:0];
          end
        end
        2'd1: for (int k = 0; k < NUM_ENTRIES; k++)
          if (int'(csr_idx) == k && !lk[k] && !tor_blk[k]) addr_d[k] = csr_wdata;
        2'd2: begin
          mml_d  = ENHANCED && (csr_wdata[0] || sec_mml);
          mmwp_d = ENHANCED && (csr_wdata[1] || sec_mmwp);
          rlb_d  = ENHANCED && csr_wdata[2] && (sec_rlb || lk == '0);
        end
        default: ;
      endcase
    end
    chg = 1'b0;
    for (int k = 0; k < NUM_ENTRIES; k++)
      chg = chg | (cfg_d[k] != cfg_q[k]) | (addr_d[k] != addr_q[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_ENTRIES; k++) begin
        cfg_q[k]  <= '0;
        addr_q[k] <= '0;
      end
      sec_mml      <= 1'b0;
      sec_mmwp     <= 1'b0;
      sec_rlb      <= 1'b0;
      rule_changed <= 1'b0;
    end else begin
      cfg_q        <= cfg_d;
      addr_q       <= addr_d;
      sec_mml      <= mml_d;
      sec_mmwp     <= mmwp_d;
      sec_rlb      <= rlb_d;
      rule_changed <= chg;
    end
  end

  always_comb begin
    csr_rdata = '0;
    case (csr_sel)
      2'd0: for (int i = 0; i < BPW; i++) begin
        int e;
        e = int'(csr_idx) * 4 + i;
        if (e < NUM_ENTRIES) csr_rdata[i*8 +: 8] = cfg_q[AW'(e)];
      end
      2'd1: if (int'(csr_idx) < NUM_ENTRIES) csr_rdata = addr_q[csr_idx[AW-1:0]];
      2'd2: csr_rdata[2:0] = {sec_rlb, sec_mmwp, sec_mml};
      default: ;
    endcase
  end
endmodule

// File: rtl/pmp_csr_bank_chk.sv
module pmp_csr_bank_chk #(
  parameter int NUM_ENTRIES = 16,
  parameter int XLEN        = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        csr_we,
  input logic [NUM_ENTRIES*8-1:0]    cfg_flat,
  input logic [NUM_ENTRIES*XLEN-1:0] addr_flat,
  input logic                        sec_mml,
  input logic                        sec_mmwp,
  input logic                        sec_rlb,
  input logic                        rule_changed
);
  logic any_l;
  always_comb begin
    any_l = 1'b0;
    for (int k = 0; k < NUM_ENTRIES; k++) any_l = any_l | cfg_flat[k*8+7];
  end

  assert_mml_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sec_mml |=> sec_mml);
  assert_mmwp_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sec_mmwp |=> sec_mmwp);
  assert_rlb_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_rlb && any_l) |=> !sec_rlb);
  assert_pulse_needs_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_we |=> !rule_changed);

  for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_chk
    assert_cfg_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_flat[k*8+7] && !sec_rlb && !sec_mml) |=> $stable(cfg_flat[k*8 +: 8]));
    assert_addr_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_flat[k*8+7] && !sec_rlb) |=> $stable(addr_flat[k*XLEN +: XLEN]));
  end
endmodule

bind pmp_csr_bank pmp_csr_bank_chk #(.NUM_ENTRIES(NUM_ENTRIES), .XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .cfg_flat(cfg_flat), .addr_flat(addr_flat),
  .sec_mml(sec_mml), .sec_mmwp(sec_mmwp), .sec_rlb(sec_rlb), .rule_changed(rule_changed));

// File: tb/pmp_csr_bank_bench.sv
module pmp_csr_bank_bench;
  logic clk = 1'b0, rst_n = 1'b0, csr_we = 1'b0;
  logic [1:0] csr_sel = '0;
  logic [4:0] csr_idx = '0;
  logic [31:0] csr_wdata = '0, csr_rdata;
  logic [127:0] cfg_flat;
  logic [511:0] addr_flat;
  logic sec_mml, sec_mmwp, sec_rlb, rule_changed;
  int checks = 0, failures = 0;
  logic pulse_seen;

  always #5 clk = ~clk;

  pmp_csr_bank u_pmp_csr_bank (.*);

  // {sel, idx, wdata, expected readback}
  localparam logic [70:0] VEC [7] = '{
    {2'd0, 5'd0,  32'h121F0A09, 32'h101F0809},  // R2 R3
    {2'd1, 5'd3,  32'hDEADBEEF, 32'hDEADBEEF},  // R2
    {2'd1, 5'd15, 32'h00001234, 32'h00001234},  // R2
    {2'd0, 5'd3,  32'h03020100, 32'h03000100},  // R2 R3
    {2'd1, 5'd20, 32'h00000005, 32'h00000000},  // R10
    {2'd0, 5'd4,  32'hFFFFFFFF, 32'h00000000},  // R10
    {2'd2, 5'd0,  32'h00000000, 32'h00000000}   // R7
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [4:0] i, input logic [31:0] d);
    @(negedge clk);
    csr_sel = s; csr_idx = i; csr_wdata = d; csr_we = 1'b1;
    @(negedge clk);
    csr_we = 1'b0;
    pulse_seen = rule_changed;
  endtask

  task automatic rd(input logic [1:0] s, input logic [4:0] i, input string req,
                    input logic [31:0] exp);
    csr_sel = s; csr_idx = i;
    #1;
    chk(req, csr_rdata, exp);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int w = 0; w < 4; w++) rd(2'd0, 5'(w), "R1", 32'h0);
    rd(2'd1, 5'd7, "R1", 32'h0);
    rd(2'd2, 5'd0, "R1", 32'h0);
    chk("R1", {31'd0, rule_changed}, 32'h0);

    for (int v = 0; v < 7; v++) begin
      wr(VEC[v][70:69], VEC[v][68:64], VEC[v][63:32]);
      rd(VEC[v][70:69], VEC[v][68:64], "R2/R3/R10 vector", VEC[v][31:0]);
    end
    rd(2'd3, 5'd0, "R2", 32'h0);

    // R11 pulse
    wr(2'd1, 5'd5, 32'h7);
    chk("R11", {31'd0, pulse_seen}, 32'h1);
    @(negedge clk);
    chk("R11", {31'd0, rule_changed}, 32'h0);
    wr(2'd1, 5'd5, 32'h7);
    chk("R11", {31'd0, pulse_seen}, 32'h0);
    wr(2'd2, 5'd0, 32'h0);
    chk("R11", {31'd0, pulse_seen}, 32'h0);

    // R6 bypass
    wr(2'd2, 5'd0, 32'h4);
    rd(2'd2, 5'd0, "R6", 32'h4);
    wr(2'd0, 5'd1, 32'h00000089);
    wr(2'd0, 5'd1, 32'h00000000);
    rd(2'd0, 5'd1, "R6", 32'h0);
    wr(2'd2, 5'd0, 32'h0);
    rd(2'd2, 5'd0, "R7", 32'h0);

    // R4 / R5 locks
    wr(2'd1, 5'd4, 32'h100);
    wr(2'd0, 5'd1, 32'h00000089);
    wr(2'd0, 5'd1, 32'h00000300);
    rd(2'd0, 5'd1, "R4", 32'h00000389);
    wr(2'd1, 5'd4, 32'h200);
    rd(2'd1, 5'd4, "R4", 32'h100);
    wr(2'd1, 5'd3, 32'h55);
    rd(2'd1, 5'd3, "R5", 32'hDEADBEEF);
    wr(2'd1, 5'd6, 32'h66);
    rd(2'd1, 5'd6, "R5", 32'h66);
    wr(2'd2, 5'd0, 32'h4);
    rd(2'd2, 5'd0, "R7", 32'h0);

    // R8 sticky
    wr(2'd2, 5'd0, 32'h1);
    rd(2'd2, 5'd0, "R8", 32'h1);
    wr(2'd2, 5'd0, 32'h0);
    rd(2'd2, 5'd0, "R8", 32'h1);
    wr(2'd2, 5'd0, 32'h2);
    wr(2'd2, 5'd0, 32'h0);
    rd(2'd2, 5'd0, "R8", 32'h3);

    // R9 lockdown filter
    wr(2'd0, 5'd1, 32'h0000038B);
    rd(2'd0, 5'd1, "R9", 32'h0000038B);
    wr(2'd0, 5'd1, 32'h0000038C);
    rd(2'd0, 5'd1, "R9", 32'h0000038B);
    wr(2'd0, 5'd1, 32'h00000306);
    rd(2'd0, 5'd1, "R9", 32'h0000038B);
    wr(2'd0, 5'd1, 32'h00000201);
    rd(2'd0, 5'd1, "R3/R9", 32'h00000201);
    wr(2'd0, 5'd1, 32'h00000601);
    rd(2'd0, 5'd1, "R9", 32'h00000201);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule